// File: doc/BRIEF.md
# SDRAM Read/Write Data Path

This block models the data side of a single-data-rate SDRAM device. It receives commands that are already decoded (read, write, precharge or no-op), a column address for each column command, and a byte mask for each cycle. Write beats go into a small internal word array. Read beats come back on the data bus after a programmable CAS latency. The 16-bit bidirectional bus is split into an input word, an output word and one output enable per byte.

A burst has 1, 2, 4 or 8 beats. Its column addresses stay inside the aligned block whose size is the burst length. The order within that block is either sequential or interleaved. A column command takes effect on the edge where it is sampled, and a new column command cuts off any burst still running. A precharge stops a read burst, and the bus goes to high impedance a CAS latency later. Burst length and order are captured by each column command. The CAS latency select is a static mode input and must be changed only while no read data is in flight.

Top module: `sdram_dpath`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `dq_oe_o` is 0 and `dq_o` is all zero until a read beat is due.
- R2: The first beat of a READ sampled at edge n is driven after edge n+2 when `cas3_i`=0, and after edge n+3 when `cas3_i`=1. Each later beat follows one cycle after the one before it.
- R3: A WRITE stores beat 0 from `dq_i` on the same edge that samples the command. Beat k is stored from `dq_i` on edge n+k.
- R4: During a write beat, a `dqm_i` bit of 1 leaves the matching stored byte unchanged, and a bit of 0 stores the new byte. Bit 0 covers bits 7:0 and bit 1 covers bits 15:8.
- R5: A `dqm_i` bit sampled at edge m sets the matching `dq_oe_o` bit after edge m+2. A value of 1 forces high impedance and a value of 0 lets a due read beat drive the bus. This 2-cycle delay does not depend on the CAS latency.
- R6: `bl_i` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. The value is captured by each READ or WRITE.
- R7: With `ilv_i`=0, beat k uses column (start+k) mod L inside the block of L columns that holds the start column.
- R8: With `ilv_i`=1, beat k uses column start XOR k inside that same aligned block.
- R9: A READ or WRITE may follow any column command on the next cycle. It ends the earlier burst at once, but read beats already issued still come out.
- R10: A PRECHARGE sampled at edge p issues no further beats. Read beats issued before edge p still appear. From edge p+2 (CL 2) or p+3 (CL 3) onward, the bus stays at high impedance.
- R11: `dq_oe_o` is low and `dq_o` is zero in any cycle when no read beat is due.
- Command encoding on `cmd_i`: 00 no-op, 01 READ, 10 WRITE, 11 PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Decoded command: 00 no-op, 01 READ, 10 WRITE, 11 PRECHARGE |
| col_i | input | COL_W (6) | Start column of a READ or WRITE |
| bl_i | input | 2 | Burst length code: 1 << bl_i beats |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cas3_i | input | 1 | CAS latency select: 0 for 2 cycles, 1 for 3 cycles |
| dq_i | input | DQ_W (16) | Input half of the data bus |
| dqm_i | input | DQ_W/8 (2) | Per-byte mask, bit b covers byte b |
| dq_o | output | DQ_W (16) | Output half of the data bus; zero where not enabled |
| dq_oe_o | output | DQ_W/8 (2) | Per-byte output enable |

## Verification
The risky overlap is a PRECHARGE that lands in the same cycle as a masked read cycle. Both the precharge cut-off and the 2-cycle mask then act on the same output slot. At CAS latency 3 that slot belongs to a beat issued one cycle before the mask was sampled. The bench sets a mask bit on the precharge cycle of a CL 3 burst. It expects exactly one byte lane to drop on the last beat that still appears, and both lanes to stay low afterwards. The same cycle-exact expectation also covers a WRITE that interrupts a read while beats are still in the latency pipeline.

// File: rtl/sdram_dpath_pkg.sv
package sdram_dpath_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_PRE   = 2'b11
  } cmd_e;

  // mask-to-output delay on reads, independent of CAS latency
  localparam int RD_MASK_LAT = 2;
endpackage

// File: rtl/sdram_dpath_burst.sv
module sdram_dpath_burst
  import sdram_dpath_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int MAX_BL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       bl_i,
  input  logic             ilv_i,
  output logic             beat_vld_o,
  output logic             beat_wr_o,
  output logic [COL_W-1:0] beat_addr_o
);
  localparam int BEAT_W = $clog2(MAX_BL) + 1;

  logic              active_q, wr_q, ilv_q;
  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] len_q, cnt_q;

  logic              start, ilv_now;
  logic [BEAT_W-1:0] len_now, beat_now;
  logic [COL_W-1:0]  base_now, blk_mask, beat_ext, off;

  assign start    = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
  assign len_now  = start ? (BEAT_W'(1) << bl_i) : len_q;
  assign base_now = start ? col_i : base_q;
  assign ilv_now  = start ? ilv_i : ilv_q;
  assign beat_now = start ? '0 : cnt_q;

  assign blk_mask = COL_W'(len_now - BEAT_W'(1));
  assign beat_ext = COL_W'(beat_now);
  assign off      = ilv_now ? (base_now ^ beat_ext) : (base_now + beat_ext);

  assign beat_addr_o = (base_now & ~blk_mask) | (off & blk_mask);
  assign beat_vld_o  = start || (active_q && cmd_i == CMD_NOP);
  assign beat_wr_o   = start ? (cmd_i == CMD_WRITE) : wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      len_q    <= BEAT_W'(1);
      cnt_q    <= '0;
    end else if (start) begin
      base_q   <= col_i;
      len_q    <= len_now;
      ilv_q    <= ilv_i;
      wr_q     <= (cmd_i == CMD_WRITE);
      cnt_q    <= BEAT_W'(1);
      active_q <= (bl_i != 2'd0);
    end else if (cmd_i == CMD_PRE) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + BEAT_W'(1);
      if (cnt_q + BEAT_W'(1) == len_q) active_q <= 1'b0;
    end
  end

  p_len_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < len_q));

  p_pre_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE) |=> !active_q);
endmodule

// File: rtl/sdram_dpath_mem.sv
module sdram_dpath_mem #(
  parameter int DQ_W   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  input  logic [DQ_W/8-1:0] be_i,
  output logic [DQ_W-1:0]   rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MASK_W = DQ_W / 8;

  logic [DQ_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < MASK_W; b++) begin
      if (wr_en_i && be_i[b]) mem_q[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  assign rdata_o = mem_q[addr_i];

  for (genvar b = 0; b < MASK_W; b++) begin : g_keep
    p_mask_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !be_i[b]) |=>
        (mem_q[$past(addr_i)][b*8 +: 8] == $past(mem_q[addr_i][b*8 +: 8])));
  end
endmodule

// File: rtl/sdram_dpath_rdpipe.sv
module sdram_dpath_rdpipe
  import sdram_dpath_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int MAX_CL = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_vld_i,
  input  logic [DQ_W-1:0]   rd_data_i,
  input  logic [DQ_W/8-1:0] dqm_i,
  input  logic              cas3_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [DQ_W/8-1:0] dq_oe_o
);
  localparam int MASK_W = DQ_W / 8;

  logic [MAX_CL-1:0] vld_q;
  logic [DQ_W-1:0]   dat_q [MAX_CL];
  logic [MASK_W-1:0] msk_q [RD_MASK_LAT];

  logic              sel_vld;
  logic [DQ_W-1:0]   sel_dat;
  logic [MASK_W-1:0] late_msk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < MAX_CL; i++) dat_q[i] <= '0;
      for (int i = 0; i < RD_MASK_LAT; i++) msk_q[i] <= '0;
    end else begin
      vld_q    <= {vld_q[MAX_CL-2:0], rd_vld_i};
      dat_q[0] <= rd_data_i;
      for (int i = 1; i < MAX_CL; i++) dat_q[i] <= dat_q[i-1];
      msk_q[0] <= dqm_i;
      for (int i = 1; i < RD_MASK_LAT; i++) msk_q[i] <= msk_q[i-1];
    end
  end

  // output register adds the last cycle of latency
  assign sel_vld  = cas3_i ? vld_q[MAX_CL-1] : vld_q[MAX_CL-2];
  assign sel_dat  = cas3_i ? dat_q[MAX_CL-1] : dat_q[MAX_CL-2];
  assign late_msk = msk_q[RD_MASK_LAT-1];

  for (genvar b = 0; b < MASK_W; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dq_oe_o[b]      <= 1'b0;
        dq_o[b*8 +: 8]  <= '0;
      end else begin
        dq_oe_o[b]      <= sel_vld && !late_msk[b];
        dq_o[b*8 +: 8]  <= (sel_vld && !late_msk[b]) ? sel_dat[b*8 +: 8] : 8'h00;
      end
    end
  end

  p_mask_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dqm_i) |-> ##3 (dq_oe_o == '0));
endmodule

// File: rtl/sdram_dpath.sv
module sdram_dpath
  import sdram_dpath_pkg::*;
#(
  parameter int  DQ_W   = 16,
  parameter int  COL_W  = 6,
  parameter int  MAX_BL = 8,
  parameter int  MAX_CL = 3,
  localparam int MASK_W = DQ_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [1:0]        bl_i,
  input  logic              ilv_i,
  input  logic              cas3_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic [MASK_W-1:0] dqm_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic [MASK_W-1:0] dq_oe_o
);
  cmd_e             cmd;
  logic             beat_vld, beat_wr;
  logic [COL_W-1:0] beat_addr;
  logic [DQ_W-1:0]  rd_data;

  assign cmd = cmd_e'(cmd_i);

  sdram_dpath_burst #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_burst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .col_i       (col_i),
    .bl_i        (bl_i),
    .ilv_i       (ilv_i),
    .beat_vld_o  (beat_vld),
    .beat_wr_o   (beat_wr),
    .beat_addr_o (beat_addr)
  );

  sdram_dpath_mem #(.DQ_W(DQ_W), .ADDR_W(COL_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (beat_vld && beat_wr),
    .addr_i  (beat_addr),
    .wdata_i (dq_i),
    .be_i    (~dqm_i),
    .rdata_o (rd_data)
  );

  sdram_dpath_rdpipe #(.DQ_W(DQ_W), .MAX_CL(MAX_CL)) u_rdpipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_vld_i  (beat_vld && !beat_wr),
    .rd_data_i (rd_data),
    .dqm_i     (dqm_i),
    .cas3_i    (cas3_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

  p_pre_hiz_cl2_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE && !cas3_i) |-> ##3 (dq_oe_o == '0));

  p_pre_hiz_cl3_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PRE && cas3_i) |-> ##4 (dq_oe_o == '0));

  p_write_no_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_WRITE) |-> ##3 (!cas3_i |-> (dq_oe_o == '0 || $past(cmd, 2) == CMD_READ
                                              || $past(cmd, 2) == CMD_NOP)));
endmodule

// File: tb/sdram_dpath_tb.sv
module sdram_dpath_tb;
  localparam logic [1:0] C_NOP = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_PRE = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = C_NOP;
  logic [5:0]  col = '0;
  logic [1:0]  bl = 2'd0;
  logic        ilv = 1'b0;
  logic        cas3 = 1'b0;
  logic [15:0] dq_in = '0;
  logic [1:0]  dqm = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  int    checks = 0;
  int    errors = 0;
  int    e = 0;
  string tag = "R1";

  logic [15:0] ref_mem [0:63];
  bit          iss_v [0:15];
  logic [15:0] iss_d [0:15];
  logic [1:0]  dqm_h [0:15];
  int m_base = 0, m_len = 1, m_cnt = 0;
  bit m_act = 0, m_wr = 0, m_ilv = 0;

  always #10 clk = ~clk;

  sdram_dpath u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .col_i(col), .bl_i(bl),
    .ilv_i(ilv), .cas3_i(cas3), .dq_i(dq_in), .dqm_i(dqm),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  function automatic logic [15:0] pat(int s);
    return 16'(s * 16'h03b5 + 16'h1c07);
  endfunction

  task automatic model(logic [1:0] c, int a, logic [15:0] d, logic [1:0] m);
    int idx = e % 16;
    int beat = 0;
    int ad;
    bit go = 0;
    iss_v[idx] = 0;
    dqm_h[idx] = m;
    if (c == C_RD || c == C_WR) begin
      m_base = a; m_len = 1 << bl; m_ilv = ilv; m_wr = (c == C_WR);
      m_act = 1; beat = 0; go = 1;
    end else if (c == C_PRE) begin
      m_act = 0;
    end else if (m_act) begin
      beat = m_cnt; go = 1;
    end
    if (go) begin
      ad = (m_base / m_len) * m_len
         + (m_ilv ? ((m_base ^ beat) % m_len) : ((m_base + beat) % m_len));
      if (m_wr) begin
        for (int b = 0; b < 2; b++) if (!m[b]) ref_mem[ad][b*8 +: 8] = d[b*8 +: 8];
      end else begin
        iss_v[idx] = 1;
        iss_d[idx] = ref_mem[ad];
      end
      m_cnt = beat + 1;
      if (m_cnt == m_len) m_act = 0;
    end
  endtask

  task automatic check_edge();
    int cl = cas3 ? 3 : 2;
    logic [1:0]  x_oe = '0;
    logic [15:0] x_dq = '0;
    for (int b = 0; b < 2; b++) begin
      if (e >= cl && iss_v[(e - cl) % 16] && !(e >= 2 && dqm_h[(e - 2) % 16][b])) begin
        x_oe[b] = 1'b1;
        x_dq[b*8 +: 8] = iss_d[(e - cl) % 16][b*8 +: 8];
      end
    end
    checks++;
    if ({dq_oe, dq_out} !== {x_oe, x_dq}) begin
      errors++;
      $display("FAIL %s edge %0d: oe=%b dq=%h expected oe=%b dq=%h",
               tag, e, dq_oe, dq_out, x_oe, x_dq);
    end
  endtask

  // drive at a falling edge, model the rising edge, check at the next falling edge
  task automatic step(logic [1:0] c, logic [5:0] a, logic [15:0] d, logic [1:0] m);
    cmd = c; col = a; dq_in = d; dqm = m;
    @(posedge clk);
    model(c, a, d, m);
    @(negedge clk);
    check_edge();
    e++;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) step(C_NOP, 6'd0, 16'h0, 2'b00);
  endtask

  task automatic wr_burst(logic [5:0] c, int seed, logic [15:0] mk);
    step(C_WR, c, pat(seed), mk[1:0]);
    for (int k = 1; k < (1 << bl); k++) step(C_NOP, 6'd0, pat(seed + k), mk[2*k +: 2]);
  endtask

  task automatic rd_burst(logic [5:0] c, logic [15:0] mk, int drain);
    step(C_RD, c, 16'h0, mk[1:0]);
    for (int k = 1; k < (1 << bl); k++) step(C_NOP, 6'd0, 16'h0, mk[2*k +: 2]);
    nops(drain);
  endtask

  task automatic t_reset();
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (dq_oe !== 2'b00 || dq_out !== 16'h0) begin
        errors++;
        $display("FAIL R1 in reset: oe=%b dq=%h expected oe=00 dq=0000", dq_oe, dq_out);
      end
    end
    rst_n = 1'b1;
    nops(3);
  endtask

  task automatic t_fill();
    tag = "R3"; bl = 2'd3; ilv = 0;
    for (int w = 0; w < 8; w++) wr_burst(6'(w * 8), w * 8, 16'h0);
    nops(2);
  endtask

  task automatic t_latency();
    tag = "R2"; bl = 2'd2; ilv = 0;
    cas3 = 0; rd_burst(6'd5, 16'h0, 5);
    cas3 = 1; rd_burst(6'd22, 16'h0, 5);
    rd_burst(6'd60, 16'h0, 5);
    cas3 = 0;
  endtask

  task automatic t_wr_mask();
    tag = "R4"; bl = 2'd1; ilv = 0;
    wr_burst(6'd40, 900, 16'b1001);
    rd_burst(6'd40, 16'h0, 5);
    bl = 2'd2;
    wr_burst(6'd44, 777, 16'b11_00_11_01);
    rd_burst(6'd44, 16'h0, 5);
  endtask

  task automatic t_rd_mask();
    tag = "R5"; bl = 2'd3; ilv = 0;
    cas3 = 0; rd_burst(6'd16, 16'b00_01_10_00_11_10_01_00, 5);
    cas3 = 1; rd_burst(6'd16, 16'b00_01_10_00_11_10_01_00, 5);
    cas3 = 0;
  endtask

  task automatic t_lengths();
    tag = "R6"; ilv = 0;
    bl = 2'd0; rd_burst(6'd9, 16'h0, 4);
    bl = 2'd0; wr_burst(6'd3, 321, 16'h0); rd_burst(6'd3, 16'h0, 4);
    bl = 2'd1; rd_burst(6'd31, 16'h0, 4);
    bl = 2'd3; rd_burst(6'd57, 16'h0, 4);
  endtask

  task automatic t_seq_wrap();
    tag = "R7"; ilv = 0; bl = 2'd3;
    rd_burst(6'd13, 16'h0, 4);
    bl = 2'd2; rd_burst(6'd39, 16'h0, 4);
  endtask

  task automatic t_interleave();
    tag = "R8"; ilv = 1;
    bl = 2'd3; rd_burst(6'd13, 16'h0, 4);
    bl = 2'd2; rd_burst(6'd6, 16'h0, 4);
    bl = 2'd2; wr_burst(6'd50, 555, 16'h0);
    ilv = 0; rd_burst(6'd48, 16'h0, 4);
    bl = 2'd3; rd_burst(6'd48, 16'h0, 4);
  endtask

  task automatic t_interrupt();
    tag = "R9"; ilv = 0; bl = 2'd3; cas3 = 0;
    step(C_RD, 6'd0, 16'h0, 2'b00);
    step(C_RD, 6'd32, 16'h0, 2'b00);
    nops(2);
    wr_burst(6'd33, 1200, 16'h0);
    step(C_RD, 6'd36, 16'h0, 2'b00);
    nops(8);
    step(C_WR, 6'd24, pat(1500), 2'b00);
    step(C_NOP, 6'd0, pat(1501), 2'b00);
    step(C_RD, 6'd24, 16'h0, 2'b00);
    nops(9);
  endtask

  task automatic t_precharge();
    tag = "R10"; ilv = 0; bl = 2'd3;
    cas3 = 0;
    step(C_RD, 6'd24, 16'h0, 2'b00);
    nops(2);
    step(C_PRE, 6'd0, 16'h0, 2'b00);
    nops(5);
    cas3 = 1;
    step(C_RD, 6'd8, 16'h0, 2'b00);
    nops(3);
    step(C_PRE, 6'd0, 16'h0, 2'b01);
    nops(5);
    step(C_PRE, 6'd0, 16'h0, 2'b00);
    nops(4);
    cas3 = 0;
  endtask

  task automatic t_idle();
    tag = "R11";
    nops(6);
    bl = 2'd2; wr_burst(6'd12, 2000, 16'h0);
    nops(4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    for (int i = 0; i < 16; i++) begin iss_v[i] = 0; iss_d[i] = '0; dqm_h[i] = '0; end
    t_reset();
    t_fill();
    t_latency();
    t_wr_mask();
    t_rd_mask();
    t_lengths();
    t_seq_wrap();
    t_interleave();
    t_interrupt();
    t_precharge();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired in %s", tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule